// File: doc/BRIEF.md
# Serial Bias and Boost Controller

This block is the slave end of a three-wire control port for a two-port line driver. A host lowers an active-low select, clocks bits on a serial clock and presents data on a single data line. The block oversamples all three lines with its own system clock. It assembles one 12-bit frame per select window. When a well-formed write arrives for one of the two port addresses, it stores the 8-bit payload in that port's configuration register.

Each configuration register drives one port. The low seven bits form the bias-current code, and a code of zero means the port is powered down. The top bit stops that port from asking for the class-G supply boost. A shared external boost request is passed to the boost output only while at least one port still permits boosting. Both registers reset to payload 0x80, so after reset both ports are powered down and boosting is off.

Top module: `bias_boost_ctrl`

## Requirements
- R1: After synchronous reset both configuration registers hold 0x80: `bias_ab` and `bias_cd` are 0, `pd_ab` and `pd_cd` are 1, and `boost_en` is 0.
- R2: The serial lines are sampled on rising `ser_clk` while `ser_csn` is low. A frame is 12 bits in this order: the write flag (1 means write), then address bits 0, 1, 2, then payload bits 0 through 7. A write frame to address 3 loads the port AB register. Its payload bits 6:0 appear on `bias_ab` within 8 clock cycles of `ser_csn` rising.
- R3: A write frame to address 7 loads the port CD register and leaves the port AB register unchanged.
- R4: A write frame to any address other than 3 or 7 changes no output.
- R5: A frame whose flag bit is 0 (a read) changes no output.
- R6: A frame is committed only if exactly 12 rising clock edges occurred while select was low. Windows with fewer edges or with more edges change no output.
- R7: Clock edges that occur while `ser_csn` is high are ignored. The next frame is decoded from its own bits only.
- R8: A port's power-down output is 1 exactly when its 7-bit code is zero, whatever the value of the register's bit 7.
- R9: `boost_en` equals `boost_req` AND NOT (AB bit 7 AND CD bit 7). A change on `boost_req` reaches `boost_en` three clock edges later, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_csn | input | 1 | Serial select, active low (asynchronous) |
| ser_clk | input | 1 | Serial clock; data taken on its rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| boost_req | input | 1 | External class-G boost request (asynchronous) |
| bias_ab | output | 7 | Bias-current code for port AB |
| pd_ab | output | 1 | Port AB power-down |
| bias_cd | output | 7 | Bias-current code for port CD |
| pd_cd | output | 1 | Port CD power-down |
| boost_en | output | 1 | Gated boost enable |

## Verification
The bench sends frames that are one bit short and one bit long. A design that commits on a count of at least twelve would load a shifted payload from the long frame. The bench sends reads and writes to all six unused addresses, which would corrupt a port if the flag or the address were decoded wrongly. It sends serial clock pulses with select high before a valid frame, which would misalign the payload if the bit counter were not cleared between windows. It sweeps all eight combinations of the two disable bits and the boost request, and checks both the cycle before and the cycle after `boost_en` is due to change. This catches an OR used in place of an AND in the gate and a synchroniser stage that was dropped.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    localparam int FRAME_BITS = 12;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int CODE_W     = DATA_W - 1;
    localparam int NPORT      = 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CNT_OVER   = FRAME_BITS + 1;

    // Port p answers to address slice p of this map (AB = 3, CD = 7).
    localparam logic [NPORT*ADDR_W-1:0] PORT_ADDR_MAP = {3'd7, 3'd3};
    localparam logic [DATA_W-1:0]       CFG_RESET     = 8'h80;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              boost_off;
        logic [CODE_W-1:0] code;
    } port_cfg_t;

    // Shift register fills from the top, so the first bit ends in bit 0.
    function automatic frame_t unpack_frame(input logic [FRAME_BITS-1:0] sr);
        frame_t f;
        f.wr   = sr[0];
        f.addr = sr[ADDR_W:1];
        f.data = sr[FRAME_BITS-1:ADDR_W+1];
        return f;
    endfunction

    function automatic logic [ADDR_W-1:0] port_addr(input int p);
        return PORT_ADDR_MAP[p*ADDR_W +: ADDR_W];
    endfunction

    function automatic logic is_powered_down(input port_cfg_t c);
        return c.code == '0;
    endfunction

endpackage

// File: rtl/bbc_sync.sv
module bbc_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= RST_VAL;
            end else if (s == 0) begin
                stg[s] <= d;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bbc_frame_rx.sv
module bbc_frame_rx
    import bbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             csn_s,
    input  logic             sclk_s,
    input  logic             dat_s,
    output logic             frame_vld,
    output frame_t           frame_q,
    output logic [CNT_W-1:0] bit_cnt
);

    logic                  sclk_d;
    logic                  csn_d;
    logic                  dat_d;
    logic                  sclk_rise;
    logic                  csn_rise;
    logic [FRAME_BITS-1:0] shreg;
    logic                  full_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
            dat_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
            dat_d  <= dat_s;
        end
    end

    assign sclk_rise  = sclk_s & ~sclk_d;
    assign csn_rise   = csn_s & ~csn_d;
    assign full_frame = (bit_cnt == CNT_W'(FRAME_BITS));

    // Counter saturates one past the frame length so long windows are rejected.
    always_ff @(posedge clk) begin
        if (rst || csn_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise && bit_cnt != CNT_W'(CNT_OVER)) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Data is taken one cycle behind its synchroniser so it predates the edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (!csn_s && sclk_rise) begin
            shreg <= {dat_d, shreg[FRAME_BITS-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_vld <= 1'b0;
            frame_q   <= '0;
        end else begin
            frame_vld <= csn_rise && full_frame;
            frame_q   <= unpack_frame(shreg);
        end
    end

endmodule

// File: rtl/bbc_port_regs.sv
module bbc_port_regs
    import bbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_vld,
    input  frame_t                frame_q,
    output port_cfg_t [NPORT-1:0] cfg_q
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_cfg_t reg_q;
        logic      hit;

        assign hit = frame_vld && frame_q.wr && (frame_q.addr == port_addr(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q <= port_cfg_t'(CFG_RESET);
            end else if (hit) begin
                reg_q <= port_cfg_t'(frame_q.data);
            end
        end

        assign cfg_q[p] = reg_q;
    end

endmodule

// File: rtl/bbc_boost_gate.sv
module bbc_boost_gate
    import bbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boost_s,
    input  logic [NPORT-1:0] off_vec,
    output logic             boost_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            boost_en <= 1'b0;
        end else begin
            boost_en <= boost_s & ~(&off_vec);
        end
    end

endmodule

// File: rtl/bias_boost_ctrl.sv
module bias_boost_ctrl
    import bbc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_csn,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              boost_req,
    output logic [CODE_W-1:0] bias_ab,
    output logic              pd_ab,
    output logic [CODE_W-1:0] bias_cd,
    output logic              pd_cd,
    output logic              boost_en
);

    localparam logic [3:0] PIN_RST = 4'b1001;

    logic [3:0]            pin_s;
    logic                  csn_s;
    logic                  sclk_s;
    logic                  dat_s;
    logic                  boost_s;
    logic                  frame_vld;
    frame_t                frame_q;
    logic [CNT_W-1:0]      bit_cnt;
    port_cfg_t [NPORT-1:0] cfg_q;
    logic [NPORT-1:0]      off_vec;

    bbc_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({boost_req, ser_dat, ser_clk, ser_csn}),
        .q   (pin_s)
    );

    assign csn_s   = pin_s[0];
    assign sclk_s  = pin_s[1];
    assign dat_s   = pin_s[2];
    assign boost_s = pin_s[3];

    bbc_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .csn_s     (csn_s),
        .sclk_s    (sclk_s),
        .dat_s     (dat_s),
        .frame_vld (frame_vld),
        .frame_q   (frame_q),
        .bit_cnt   (bit_cnt)
    );

    bbc_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .frame_q   (frame_q),
        .cfg_q     (cfg_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_off
        assign off_vec[p] = cfg_q[p].boost_off;
    end

    bbc_boost_gate u_boost (
        .clk      (clk),
        .rst      (rst),
        .boost_s  (boost_s),
        .off_vec  (off_vec),
        .boost_en (boost_en)
    );

    assign bias_ab = cfg_q[0].code;
    assign pd_ab   = is_powered_down(cfg_q[0]);
    assign bias_cd = cfg_q[1].code;
    assign pd_cd   = is_powered_down(cfg_q[1]);

endmodule

// File: rtl/bbc_checker.sv
module bbc_checker
    import bbc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  boost_s,
    input logic                  frame_vld,
    input frame_t                frame_q,
    input logic [CNT_W-1:0]      bit_cnt,
    input port_cfg_t [NPORT-1:0] cfg_q,
    input logic                  boost_en
);

    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    // R1: the cycle that follows reset shows the default configuration.
    always @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0) begin
            a_r1_reset_defaults: assert (cfg_q[0] == port_cfg_t'(CFG_RESET)
                                         && cfg_q[1] == port_cfg_t'(CFG_RESET)
                                         && !boost_en)
                else $error("reset defaults wrong");
        end
    end

    a_r2_ab_needs_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q[0]) |-> $past(frame_vld && frame_q.wr && frame_q.addr == 3'd3))
        else $error("AB register changed without a write to address 3");

    a_r3_cd_needs_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q[1]) |-> $past(frame_vld && frame_q.wr && frame_q.addr == 3'd7))
        else $error("CD register changed without a write to address 7");

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(CNT_OVER))
        else $error("bit counter beyond saturation");

    a_r9_both_off_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_q[0].boost_off && cfg_q[1].boost_off) |-> !boost_en)
        else $error("boost enabled although both ports disable it");

    a_r9_low_request_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(!boost_s) |-> !boost_en)
        else $error("boost enabled without a request");

endmodule

bind bias_boost_ctrl bbc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .boost_s   (boost_s),
    .frame_vld (frame_vld),
    .frame_q   (frame_q),
    .bit_cnt   (bit_cnt),
    .cfg_q     (cfg_q),
    .boost_en  (boost_en)
);

// File: tb/test_bias_boost_ctrl.sv
module test_bias_boost_ctrl;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_csn = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       boost_req = 1'b1;
    logic [6:0] bias_ab;
    logic       pd_ab;
    logic [6:0] bias_cd;
    logic       pd_cd;
    logic       boost_en;

    int         checks = 0;
    int         failures = 0;
    logic [7:0] exp_ab = 8'h80;
    logic [7:0] exp_cd = 8'h80;

    always #2 clk = ~clk;

    bias_boost_ctrl i_bias_boost_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ser_csn   (ser_csn),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .boost_req (boost_req),
        .bias_ab   (bias_ab),
        .pd_ab     (pd_ab),
        .bias_cd   (bias_cd),
        .pd_cd     (pd_cd),
        .boost_en  (boost_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, "bias_ab", 32'(bias_ab), 32'(exp_ab[6:0]));
        check(req, "pd_ab", 32'(pd_ab), 32'(exp_ab[6:0] == 7'd0));
        check(req, "bias_cd", 32'(bias_cd), 32'(exp_cd[6:0]));
        check(req, "pd_cd", 32'(pd_cd), 32'(exp_cd[6:0] == 7'd0));
        check(req, "boost_en", 32'(boost_en),
              32'(boost_req & ~(exp_ab[7] & exp_cd[7])));
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        ser_csn = 1'b0;
        tick(4);
        for (int i = 0; i < n; i++) begin
            ser_dat = bits[i];
            tick(HALF);
            ser_clk = 1'b1;
            tick(HALF);
            ser_clk = 1'b0;
        end
        tick(4);
        ser_csn = 1'b1;
        tick(16);
    endtask

    task automatic send(input logic wr, input logic [2:0] addr,
                        input logic [7:0] data, input int n);
        shift_bits({4'b1010, data, addr, wr}, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1: defaults after reset
        check_outputs("R1");

        // R2 / R3: sweep payloads across both ports
        for (int k = 0; k < 64; k++) begin
            logic [7:0] d;
            d = 8'((k * 37 + 5) & 255);
            if (k[0]) begin
                send(1'b1, 3'd7, d, 12);
                exp_cd = d;
                check_outputs("R3");
            end else begin
                send(1'b1, 3'd3, d, 12);
                exp_ab = d;
                check_outputs("R2");
            end
        end

        // R8: code zero with and without bit 7, full-scale code
        send(1'b1, 3'd3, 8'h00, 12); exp_ab = 8'h00; check_outputs("R8");
        send(1'b1, 3'd7, 8'h80, 12); exp_cd = 8'h80; check_outputs("R8");
        send(1'b1, 3'd3, 8'h7F, 12); exp_ab = 8'h7F; check_outputs("R8");
        send(1'b1, 3'd7, 8'h01, 12); exp_cd = 8'h01; check_outputs("R8");

        // R4: every other address is ignored
        for (int a = 0; a < 8; a++) begin
            if (a != 3 && a != 7) begin
                send(1'b1, 3'(a), 8'h55, 12);
                check_outputs("R4");
            end
        end

        // R5: read frames are ignored
        send(1'b0, 3'd3, 8'h11, 12); check_outputs("R5");
        send(1'b0, 3'd7, 8'h92, 12); check_outputs("R5");

        // R6: short and long windows are ignored, exact one accepted
        send(1'b1, 3'd3, 8'h22, 11); check_outputs("R6");
        send(1'b1, 3'd3, 8'h22, 1);  check_outputs("R6");
        send(1'b1, 3'd7, 8'h33, 13); check_outputs("R6");
        send(1'b1, 3'd3, 8'h44, 0);  check_outputs("R6");
        send(1'b1, 3'd3, 8'h44, 12); exp_ab = 8'h44; check_outputs("R6");

        // R7: clock pulses with select high leave no trace
        ser_dat = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick(HALF); ser_clk = 1'b1; tick(HALF); ser_clk = 1'b0;
        end
        tick(4);
        check_outputs("R7");
        send(1'b1, 3'd7, 8'h2C, 12); exp_cd = 8'h2C; check_outputs("R7");

        // R9: all disable-bit and request combinations, with latency
        for (int c = 0; c < 8; c++) begin
            logic [7:0] va;
            logic [7:0] vc;
            logic       old_en;
            va = {c[0], 7'h10};
            vc = {c[1], 7'h21};
            send(1'b1, 3'd3, va, 12); exp_ab = va;
            send(1'b1, 3'd7, vc, 12); exp_cd = vc;
            boost_req = ~c[2];
            tick(8);
            check_outputs("R9");
            old_en = boost_en;
            boost_req = c[2];
            tick(2);
            check("R9", "boost_en before latency", 32'(boost_en), 32'(old_en));
            tick(1);
            check("R9", "boost_en after latency", 32'(boost_en),
                  32'(c[2] & ~(c[0] & c[1])));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule